// File: doc/BRIEF.md
# Serial Host Register Port

This block lets a controller reach a bank of 8-bit registers over a four-wire synchronous link made of an active-low select, a serial clock, a data input and a data output. Each access starts with a command byte that names the register and the direction. A write then shifts in one data byte. A read shifts one byte back out, least significant bit first. The data output has its own enable, which goes to the pad driver. The enable is high only while a read is actually presenting bits.

A single edge-select input chooses the serial-clock edge at which the controller samples read data. The same input chooses which edge of a receive clock the retimed line-data pair is valid on. All link inputs are brought into the block's own clock through two-stage synchronizers, and edges are detected from the synchronized copies. The serial clock must therefore run several times slower than the block clock.

Registers 0 to 11 are control registers. They can be written, and their contents appear on a flat output bus. Registers 12 to 15 return a status input bus and cannot be written. Addresses 16 to 31 read as zero.

Top module: `hostreg_port`

## Requirements
- R1: An access starts only when cs_n is seen going from high to low. A cs_n held low since reset opens no access. cs_n going high ends any access, and the next falling edge of cs_n starts a new one from the command byte.
- R2: The command byte is shifted in on the first 8 rising sclk edges, least significant bit first. Bit 0 selects the direction (1 = read, 0 = write). Bits 5:1 hold the register address. Bits 7:6 are ignored.
- R3: For a write, rising sclk edges 9 to 16 carry the data byte, least significant bit first. The register is updated when the 16th rising edge is detected. Further edges before deselect are ignored.
- R4: A write whose cs_n rises before the 16th rising sclk edge leaves every register unchanged.
- R5: Addresses 0 to 11 are control registers. Register k drives ctrl_out[8k+7:8k]. Addresses 12 to 15 read status_in[8(a-12)+7:8(a-12)], and writes to them are ignored. Addresses 16 to 31 read as 0x00, and writes to them are ignored.
- R6: A read returns the addressed byte with D0 first and D7 last. Back-to-back transfers each return their own byte.
- R7: With edge_sel = 1, sdo changes only after falling sclk edges and is sampled by the controller on rising edges. D0 first appears after the falling edge that follows the 8th rising edge.
- R8: With edge_sel = 0, sdo changes only after rising sclk edges and is sampled by the controller on falling edges. D0 appears right after the 8th rising edge.
- R9: sdo_oe stays low throughout a write and outside reads. It drops after the sampling edge of D7, or when cs_n goes high, whichever comes first.
- R10: With edge_sel = 1, rpos/rneg take rx_pos/rx_neg at rising rclk edges, so they are valid on falling edges. With edge_sel = 0, they take them at falling edges, so they are valid on rising edges.
- R11: After reset, sdo_oe, ctrl_out, rpos and rneg are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_sel | input | 1 | Edge select for read data and receive data |
| cs_n | input | 1 | Active-low select of the serial link |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data from controller |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Drive enable for sdo pad |
| status_in | input | 32 | Status bytes behind addresses 12..15 |
| ctrl_out | output | 96 | Control register contents, register 0 in low byte |
| rclk | input | 1 | Receive clock |
| rx_pos | input | 1 | Recovered positive-pulse data |
| rx_neg | input | 1 | Recovered negative-pulse data |
| rpos | output | 1 | Retimed positive-pulse data |
| rneg | output | 1 | Retimed negative-pulse data |

## Verification
The assertions assume that every serial-clock and receive-clock phase lasts well beyond the synchronizer and edge-detect latency, and that edge_sel changes only while cs_n is high. They also assume that cs_n never moves within a few block clocks of an sclk edge. The stimulus keeps each sclk phase at six block clocks and each rclk phase at eight. It waits several block clocks between a cs_n edge and the nearest sclk edge, and it changes edge_sel only between transfers.

// File: rtl/hostreg_port.sv
module hostreg_port #(
  parameter int DW    = 8,
  parameter int NREG  = 16,
  parameter int NSTAT = 4,
  parameter int AW    = 5,
  parameter int SYNC  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        edge_sel,
  input  logic                        cs_n,
  input  logic                        sclk,
  input  logic                        sdi,
  output logic                        sdo,
  output logic                        sdo_oe,
  input  logic [NSTAT*DW-1:0]         status_in,
  output logic [(NREG-NSTAT)*DW-1:0]  ctrl_out,
  input  logic                        rclk,
  input  logic                        rx_pos,
  input  logic                        rx_neg,
  output logic                        rpos,
  output logic                        rneg
);
  localparam int NCTL = NREG - NSTAT;
  localparam int CW   = $clog2(2*DW+1);
  localparam int BW   = $clog2(DW) + 1;

  logic [SYNC:0]   sclk_p, cs_p, rclk_p;
  logic [SYNC-1:0] sdi_p, rxp_p, rxn_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_p <= '0; cs_p <= '0; rclk_p <= '0;
      sdi_p  <= '0; rxp_p <= '0; rxn_p <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC-1:0], sclk};
      cs_p   <= {cs_p[SYNC-1:0], cs_n};
      rclk_p <= {rclk_p[SYNC-1:0], rclk};
      sdi_p  <= {sdi_p[SYNC-2:0], sdi};
      rxp_p  <= {rxp_p[SYNC-2:0], rx_pos};
      rxn_p  <= {rxn_p[SYNC-2:0], rx_neg};
    end

  wire s_rise  = sclk_p[SYNC-1] & ~sclk_p[SYNC];
  wire s_fall  = ~sclk_p[SYNC-1] & sclk_p[SYNC];
  wire r_rise  = rclk_p[SYNC-1] & ~rclk_p[SYNC];
  wire r_fall  = ~rclk_p[SYNC-1] & rclk_p[SYNC];
  wire cs_hi   = cs_p[SYNC-1];
  wire cs_fall = ~cs_p[SYNC-1] & cs_p[SYNC];
  wire launch  = edge_sel ? s_fall : s_rise;
  wire samp    = edge_sel ? s_rise : s_fall;
  wire rlaunch = edge_sel ? r_rise : r_fall;

  logic          active;
  logic [CW-1:0] cnt;
  logic [BW-1:0] rptr;
  logic [DW-2:0] sh;
  logic [AW:0]   cmd;
  logic [DW-1:0] ctl [NCTL];
  logic [DW-1:0] rd_word;

  wire [DW-1:0] nxt     = {sdi_p[SYNC-1], sh};
  wire [AW:0]   cur_cmd = (cnt == CW'(DW-1)) ? nxt[AW:0] : cmd;
  wire [AW-1:0] addr    = cur_cmd[AW:1];
  wire          rd_win  = cur_cmd[0] && (rptr < BW'(DW)) &&
                          (edge_sel ? (cnt >= CW'(DW)) : (cnt >= CW'(DW-1)));

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NCTL; i++)
      if (32'(addr) == i) rd_word = ctl[i];
    for (int j = 0; j < NSTAT; j++)
      if (32'(addr) == NCTL + j) rd_word = status_in[j*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0; cnt <= '0; rptr <= '0; sh <= '0; cmd <= '0;
      sdo <= 1'b0; sdo_oe <= 1'b0;
      for (int i = 0; i < NCTL; i++) ctl[i] <= '0;
    end else if (cs_hi) begin
      active <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (cs_fall) begin
      active <= 1'b1;
      cnt    <= '0;
      rptr   <= '0;
      sdo_oe <= 1'b0;
    end else if (active) begin
      if (s_rise && cnt != CW'(2*DW)) begin
        sh  <= nxt[DW-1:1];
        cnt <= cnt + 1'b1;
        if (cnt == CW'(DW-1)) cmd <= nxt[AW:0];
        if (cnt == CW'(2*DW-1) && !cmd[0])
          for (int i = 0; i < NCTL; i++)
            if (32'(cmd[AW:1]) == i) ctl[i] <= nxt;
      end
      if (launch && rd_win) begin
        sdo    <= rd_word[rptr[BW-2:0]];
        sdo_oe <= 1'b1;
        rptr   <= rptr + 1'b1;
      end else if (samp && cnt == CW'(2*DW-1)) begin
        sdo_oe <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rpos <= 1'b0; rneg <= 1'b0;
    end else if (rlaunch) begin
      rpos <= rxp_p[SYNC-1];
      rneg <= rxn_p[SYNC-1];
    end

  for (genvar g = 0; g < NCTL; g++) begin : g_out
    assign ctrl_out[g*DW +: DW] = ctl[g];
  end
endmodule

// File: rtl/hostreg_port_chk.sv
module hostreg_port_chk #(
  parameter int DW = 8,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          cs_fall,
  input logic          active,
  input logic [CW-1:0] cnt,
  input logic          cmd_rw,
  input logic          sdo,
  input logic          sdo_oe,
  input logic          launch,
  input logic          rlaunch,
  input logic          rpos,
  input logic          rneg
);
  // R1
  access_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !$past(active)) |-> $past(cs_fall));

  // R9
  deselect_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);

  // R9
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt >= CW'(DW) && !cmd_rw) |-> !sdo_oe);

  // R7
  sdo_launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$stable(sdo)) |-> $past(launch));

  // R10
  rx_launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rpos) || !$stable(rneg)) |-> $past(rlaunch));
endmodule

bind hostreg_port hostreg_port_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_fall(cs_fall),
  .active(active), .cnt(cnt), .cmd_rw(cmd[0]), .sdo(sdo),
  .sdo_oe(sdo_oe), .launch(launch), .rlaunch(rlaunch),
  .rpos(rpos), .rneg(rneg)
);

// File: tb/hostreg_port_test.sv
module hostreg_port_test;
  localparam int CLK_P = 10;
  localparam int H     = 6;

  logic clk = 0, rst_n = 0, edge_sel = 1, cs_n = 0, sclk = 0, sdi = 0;
  logic rclk = 0, rx_pos = 0, rx_neg = 0;
  logic sdo, sdo_oe, rpos, rneg;
  logic [31:0] status_in = {8'h3C, 8'h96, 8'hE1, 8'h5A};
  logic [95:0] ctrl_out;

  hostreg_port uut (
    .clk(clk), .rst_n(rst_n), .edge_sel(edge_sel), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .status_in(status_in),
    .ctrl_out(ctrl_out), .rclk(rclk), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .rpos(rpos), .rneg(rneg)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0, nb = 0;
  logic [7:0] q[$];
  logic [7:0] acc, e;
  logic [7:0] mctl [12];
  logic oe_mid, oe_end, oe_any;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] model();
    logic [95:0] v;
    for (int i = 0; i < 12; i++) v[i*8 +: 8] = mctl[i];
    return v;
  endfunction

  function automatic logic [7:0] mk(input bit rd, input int a);
    return {2'b00, 5'(a), rd};
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: pushes expected read bytes and models register writes
  task automatic xfer(input logic [7:0] cmd, input logic [7:0] wd, input int n,
                      input bit push, input logic [7:0] exp);
    if (push) q.push_back(exp);
    if (!cmd[0] && n >= 16 && cmd[5:1] < 12) mctl[cmd[5:1]] = wd;
    oe_any = 0; oe_mid = 0;
    cs_n = 0;
    for (int i = 0; i < n; i++) begin
      sdi = (i < 8) ? cmd[i] : ((i < 16) ? wd[i-8] : 1'b0);
      wclk(H);
      sclk = 1;
      oe_any |= sdo_oe;
      wclk(4);
      if (i == 7) oe_mid = sdo_oe;
      oe_any |= sdo_oe;
      wclk(H - 4);
      sclk = 0;
    end
    wclk(H);
    oe_end = sdo_oe;
    oe_any |= sdo_oe;
    cs_n = 1;
    wclk(10);
  endtask

  // monitor: assembles read bytes at the sampling edge and compares
  always @(sclk or cs_n) begin
    if (cs_n) nb = 0;
    else if (sdo_oe && sclk == edge_sel) begin
      acc[nb[2:0]] = sdo;
      nb++;
      if (nb == 8) begin
        nb = 0;
        if (q.size() == 0) chk(0, "R6 unexpected read byte", acc, 0);
        else begin
          e = q.pop_front();
          chk(acc == e, "R6 read byte", acc, e);
        end
      end
    end
  end

  initial begin
    wclk(150000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 12; i++) mctl[i] = 8'h00;
    wclk(5);
    rst_n = 1;
    wclk(3);
    chk(sdo_oe == 0, "R11 sdo_oe after reset", sdo_oe, 0);
    chk(ctrl_out == 0, "R11 ctrl_out after reset", ctrl_out, 0);
    chk({rpos, rneg} == 0, "R11 rx outputs after reset", {rpos, rneg}, 0);

    // R1: cs_n low since reset, write attempt is ignored
    for (int i = 0; i < 16; i++) begin
      sdi = (i < 8) ? mk(0, 0)>>i : 1'b1;
      wclk(H); sclk = 1; wclk(H); sclk = 0;
    end
    chk(ctrl_out == model(), "R1 no access without cs_n fall", ctrl_out, model());
    cs_n = 1; wclk(10);

    // R3 write, edge_sel = 1
    xfer(mk(0, 3), 8'hA5, 16, 0, 0);
    chk(ctrl_out == model(), "R3 write reg3", ctrl_out, model());
    chk(oe_any == 0, "R9 no drive during write", oe_any, 0);

    // R7 read, edge_sel = 1
    xfer(mk(1, 3), 0, 16, 1, 8'hA5);
    chk(oe_mid == 0, "R7 no data before falling edge", oe_mid, 0);
    chk(q.size() == 0, "R7 read consumed", q.size(), 0);
    chk(sdo_oe == 0, "R9 released after D7", sdo_oe, 0);

    // R8 read, edge_sel = 0
    edge_sel = 0; wclk(4);
    xfer(mk(1, 3), 0, 16, 1, 8'hA5);
    chk(oe_mid == 1, "R8 D0 after 8th rising edge", oe_mid, 1);
    chk(q.size() == 0, "R8 read consumed", q.size(), 0);
    chk(oe_end == 0, "R9 released after D7 sample", oe_end, 0);

    // R6 back-to-back transfers
    xfer(mk(0, 0), 8'h1B, 16, 0, 0);
    xfer(mk(0, 11), 8'hC4, 16, 0, 0);
    xfer(mk(1, 0), 0, 16, 1, 8'h1B);
    xfer(mk(1, 11), 0, 16, 1, 8'hC4);
    chk(ctrl_out == model(), "R6 back-to-back writes", ctrl_out, model());
    chk(q.size() == 0, "R6 back-to-back reads", q.size(), 0);

    // R5 status and unmapped addresses
    xfer(mk(0, 13), 8'hFF, 16, 0, 0);
    chk(ctrl_out == model(), "R5 status write ignored", ctrl_out, model());
    xfer(mk(1, 13), 0, 16, 1, 8'hE1);
    edge_sel = 1; wclk(4);
    xfer(mk(1, 12), 0, 16, 1, 8'h5A);
    xfer(mk(0, 20), 8'h77, 16, 0, 0);
    chk(ctrl_out == model(), "R5 unmapped write ignored", ctrl_out, model());
    xfer(mk(1, 20), 0, 16, 1, 8'h00);
    chk(q.size() == 0, "R5 status reads", q.size(), 0);

    // R2 reserved command bits
    xfer(mk(0, 5) | 8'hC0, 8'h3C, 16, 0, 0);
    chk(ctrl_out == model(), "R2 reserved bits ignored on write", ctrl_out, model());
    xfer(mk(1, 5) | 8'hC0, 0, 16, 1, 8'h3C);
    chk(q.size() == 0, "R2 reserved bits ignored on read", q.size(), 0);

    // R3 extra edges ignored
    xfer(mk(0, 7), 8'h69, 20, 0, 0);
    chk(ctrl_out == model(), "R3 extra edges ignored", ctrl_out, model());

    // R4 aborted writes, both edge settings
    xfer(mk(0, 3), 8'h00, 12, 0, 0);
    chk(ctrl_out == model(), "R4 aborted write es1", ctrl_out, model());
    edge_sel = 0; wclk(4);
    xfer(mk(0, 7), 8'hFF, 15, 0, 0);
    chk(ctrl_out == model(), "R4 aborted write es0", ctrl_out, model());

    // R9 aborted reads, both edge settings
    xfer(mk(1, 3), 0, 11, 0, 0);
    chk(oe_end == 1, "R9 driving before deselect es0", oe_end, 1);
    chk(sdo_oe == 0, "R9 released on deselect es0", sdo_oe, 0);
    edge_sel = 1; wclk(4);
    xfer(mk(1, 3), 0, 11, 0, 0);
    chk(oe_end == 1, "R9 driving before deselect es1", oe_end, 1);
    chk(sdo_oe == 0, "R9 released on deselect es1", sdo_oe, 0);

    // R1 new access after abort starts from the command byte
    xfer(mk(1, 3), 0, 16, 1, 8'hA5);
    chk(q.size() == 0, "R1 restart after abort", q.size(), 0);

    // R10 receive retiming, edge_sel = 1: captured at rising rclk
    rx_pos = 1; rx_neg = 0; wclk(8);
    rclk = 1; wclk(4);
    rx_pos = 0; rx_neg = 1; wclk(4);
    chk({rpos, rneg} == 2'b10, "R10 es1 captured at rise", {rpos, rneg}, 2'b10);
    rclk = 0; wclk(6);
    chk({rpos, rneg} == 2'b10, "R10 es1 falling edge holds", {rpos, rneg}, 2'b10);
    wclk(2); rclk = 1; wclk(6);
    chk({rpos, rneg} == 2'b01, "R10 es1 next rise", {rpos, rneg}, 2'b01);

    // R10 edge_sel = 0: captured at falling rclk
    edge_sel = 0;
    rx_pos = 1; rx_neg = 0; wclk(8);
    rclk = 0; wclk(4);
    rx_pos = 0; rx_neg = 1; wclk(4);
    chk({rpos, rneg} == 2'b10, "R10 es0 captured at fall", {rpos, rneg}, 2'b10);
    rclk = 1; wclk(6);
    chk({rpos, rneg} == 2'b10, "R10 es0 rising edge holds", {rpos, rneg}, 2'b10);
    wclk(2); rclk = 0; wclk(6);
    chk({rpos, rneg} == 2'b01, "R10 es0 next fall", {rpos, rneg}, 2'b01);

    chk(q.size() == 0, "R6 all reads observed", q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule